// File: doc/BRIEF.md
# Command-Steered Serial Register Port

This block is the host-facing serial port of a converter-style peripheral. It is a slave on a three-wire SPI-compatible link: a serial clock, a data input and a data output. An optional active-low select may be tied low permanently. Every access starts with a one-byte command word. The command names one of eight internal registers and says whether the host reads or writes it. The port then moves exactly as many bits as that register holds, either 8, 16 or 24, most significant bit first, and afterwards waits for the next command byte. A host with an 8-bit shifter sends one, two or three bytes. A host with a wider shifter may pad with ones, and the padding is harmless.

A command byte starts at the first 0 bit seen on the data input while the port waits for a command, so idle ones are skipped. Its fields are: bit 6, 1 for a read and 0 for a write; bits 5:4, where `01` on a read of the result register starts repeated reading; bits 2:0, the register address. In repeated reading the port streams the 24-bit result word again and again. Meanwhile it watches the data input, one aligned byte at a time, for an exit byte (default `0x30`). A stub outside the block supplies conversion results through a strobe and a 24-bit word. A ready flag, readable in the status register and on an active-low pin, reports that a fresh result is waiting.

The serial clock, data input and select are brought into the system clock domain and sampled there. The polarity pin names the clock's idle level. The port samples the data input on the edge that returns the clock to idle, and changes its output on the edge that leaves idle.

Top module: `cmd_serial_port`

## Requirements
- R1: In command wait, 1 bits on the data input are skipped. A command byte begins with the first 0 bit. Its bit 6 is 1 for a read, bits 5:4 equal to `01` request repeated reading, and bits 2:0 give the address.
- R2: Register lengths are: address 0 status, 8 bits, read-only; address 1 result, 24 bits, read-only; address 2 mode, 16 bits; address 3 offset, 24 bits; address 4 setup, 8 bits; addresses 5 to 7 unused, 8 bits.
- R3: A write loads the bits that follow the command byte, MSB first, into the addressed register. After the last bit the port waits for a command again.
- R4: A read shifts the addressed register out on `dout`, MSB first, for exactly its length. After that the port waits for a command again.
- R5: Any number of 1 bits sent after an access completes changes no register and does not disturb the next command.
- R6: Outside a read access `dout` is held low. In particular it stays low through every bit of a write access.
- R7: With `pol` low the clock idles low: `din` is sampled on falling edges and `dout` changes on rising edges. With `pol` high every edge is the opposite.
- R8: The status register reads as `0x80` while a fresh result waits and `0x00` otherwise.
- R9: `rdy_n` goes low after `conv_strobe` and returns high when a read of the result register starts. A strobe in the same cycle as that start wins.
- R10: A read command with bits 5:4 equal to `01` on address 1 streams 24-bit result words back to back. Each word is taken from the result register when it starts, and each start clears the ready flag.
- R11: Repeated reading ends when the 8 `din` bits of one aligned byte of a word equal the exit byte `0x30`. The rest of that word is dropped. A `0x30` pattern that straddles a byte boundary has no effect.
- R12: While `cs_n` is high the port ignores the clock, holds `dout` low and abandons any partial access. With `cs_n` tied low it works fully.
- R13: Writes to addresses 0, 1 and 5 to 7 change nothing, and addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low select, may be tied low |
| pol | input | 1 | Serial clock idle level |
| conv_strobe | input | 1 | One-cycle pulse: a new result is on `conv_word` |
| conv_word | input | 24 | Conversion result from the stub |
| dout | output | 1 | Serial data to the host |
| rdy_n | output | 1 | Low while a fresh result waits |

## Verification
The assertions assume that `pol` changes only while reset is held. They also assume that each serial clock phase lasts longer than the synchronizer delay, and that `din` and `cs_n` are stable across the edge the port samples on. Under these assumptions each serial edge appears as exactly one internal sampling or launching event. The stimulus respects this. It holds every clock phase for six system cycles and moves `din` only on the edge that leaves idle. It changes `pol` only inside a reset, when it re-runs the whole sequence under the other polarity.

// File: rtl/csp_pkg.sv
// Shared constants, state type and register length map for the serial register port.
// Assumes at most eight registers, none wider than WORD_W bits.
package csp_pkg;
    localparam int WORD_W  = 24;
    localparam int MODE_W  = 16;
    localparam int SETUP_W = 8;
    localparam int ADDR_W  = 3;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_RESULT = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_OFFSET = 3'd3;
    localparam logic [ADDR_W-1:0] A_SETUP  = 3'd4;

    typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_CRD} port_state_e;

    // Bit length of the register at a given address.
    function automatic logic [CNT_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
        case (a)
            A_RESULT, A_OFFSET: reg_len = CNT_W'(WORD_W);
            A_MODE:             reg_len = CNT_W'(MODE_W);
            default:            reg_len = CNT_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/csp_pin_sync.sv
// Brings the serial pins into the system clock domain.
// Assumes pol is static between resets; the clock stages reset to the idle level.
module csp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pol,
    input  logic sclk,
    input  logic din,
    input  logic cs_n,
    output logic sclk_s,
    output logic din_s,
    output logic cs_n_s
);
    logic [STAGES-1:0] sclk_p, din_p, cs_p;

    // Shift each pin through its synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= {STAGES{pol}};
            din_p  <= '1;
            cs_p   <= '1;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk};
            din_p  <= {din_p[STAGES-2:0], din};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
        end
    end

    assign sclk_s = sclk_p[STAGES-1];
    assign din_s  = din_p[STAGES-1];
    assign cs_n_s = cs_p[STAGES-1];
endmodule

// File: rtl/csp_regfile.sv
// Holds the addressable registers, the result word and the ready flag.
// Assumes wr_en and take are single-cycle pulses from the shift engine.
module csp_regfile
    import csp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_value,
    input  logic              take,
    input  logic              conv_strobe,
    input  logic [WORD_W-1:0] conv_word,
    output logic              ready
);
    logic [MODE_W-1:0]  mode_q;
    logic [WORD_W-1:0]  offset_q;
    logic [SETUP_W-1:0] setup_q;
    logic [WORD_W-1:0]  result_q;

    // Host writes to the writable registers; read-only and unused addresses drop the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            offset_q <= '0;
            setup_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:   mode_q   <= wr_data[MODE_W-1:0];
                A_OFFSET: offset_q <= wr_data;
                A_SETUP:  setup_q  <= wr_data[SETUP_W-1:0];
                default:  ;
            endcase
        end
    end

    // Result capture and ready flag; a new result beats a simultaneous take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            ready    <= 1'b0;
        end else if (conv_strobe) begin
            result_q <= conv_word;
            ready    <= 1'b1;
        end else if (take) begin
            ready    <= 1'b0;
        end
    end

    // Read mux, values right-aligned.
    always_comb begin
        case (rd_addr)
            A_STATUS: rd_value = {{(WORD_W-8){1'b0}}, ready, 7'b0};
            A_RESULT: rd_value = result_q;
            A_MODE:   rd_value = {{(WORD_W-MODE_W){1'b0}}, mode_q};
            A_OFFSET: rd_value = offset_q;
            A_SETUP:  rd_value = {{(WORD_W-SETUP_W){1'b0}}, setup_q};
            default:  rd_value = '0;
        endcase
    end
endmodule

// File: rtl/csp_shift_engine.sv
// Command decoder and bit shifter of the serial port.
// Assumes synchronized pins whose clock phases each span several system cycles.
module csp_shift_engine
    import csp_pkg::*;
#(
    parameter logic [7:0] EXIT_CODE = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pol,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              cs_n_s,
    input  logic [WORD_W-1:0] rd_value,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              take,
    output logic              dout,
    output port_state_e       st_q,
    output logic [CNT_W-1:0]  cnt_q
);
    logic              norm, norm_d, lead, trail;
    logic [WORD_W-2:0] rx_q;
    logic [WORD_W-1:0] tx_q;
    logic [CNT_W-1:0]  len_q, new_len;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        cbyte;
    logic              last_bit, cmd_done, is_read, want_cont, exit_hit;

    assign norm  = sclk_s ^ pol;
    assign lead  = !cs_n_s && norm && !norm_d;
    assign trail = !cs_n_s && !norm && norm_d;

    // Remember the polarity-normalized clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) norm_d <= 1'b0;
        else        norm_d <= norm;
    end

    assign cbyte     = {rx_q[6:0], din_s};
    assign new_len   = reg_len(cbyte[ADDR_W-1:0]);
    assign last_bit  = (cnt_q == len_q - CNT_W'(1));
    assign cmd_done  = trail && (st_q == ST_CMD) && (cnt_q == CNT_W'(7));
    assign is_read   = cbyte[6];
    assign want_cont = is_read && (cbyte[5:4] == 2'b01) && (cbyte[ADDR_W-1:0] == A_RESULT);
    assign exit_hit  = trail && (st_q == ST_CRD) && (cnt_q[2:0] == 3'd7) && (cbyte == EXIT_CODE);
    assign rd_addr   = (st_q == ST_CMD) ? cbyte[ADDR_W-1:0] : addr_q;
    assign take      = (cmd_done && is_read && (cbyte[ADDR_W-1:0] == A_RESULT))
                     || (trail && (st_q == ST_CRD) && last_bit && !exit_hit);
    assign wr_en     = trail && (st_q == ST_WR) && last_bit;
    assign wr_addr   = addr_q;
    assign wr_data   = {rx_q, din_s};

    // Access sequencing: sample on the return-to-idle edge, launch on the leaving edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_CMD;
            cnt_q  <= '0;
            len_q  <= CNT_W'(8);
            addr_q <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            dout   <= 1'b0;
        end else if (cs_n_s) begin
            st_q  <= ST_CMD;
            cnt_q <= '0;
            dout  <= 1'b0;
        end else if (lead) begin
            if (st_q == ST_RD || st_q == ST_CRD) begin
                dout <= tx_q[WORD_W-1];
                tx_q <= tx_q << 1;
            end else begin
                dout <= 1'b0;
            end
        end else if (trail) begin
            case (st_q)
                ST_CMD: begin
                    if (!(cnt_q == '0 && din_s)) begin
                        rx_q <= {rx_q[WORD_W-3:0], din_s};
                        if (cmd_done) begin
                            cnt_q  <= '0;
                            addr_q <= cbyte[ADDR_W-1:0];
                            len_q  <= new_len;
                            if (is_read) begin
                                tx_q <= rd_value << (CNT_W'(WORD_W) - new_len);
                                st_q <= want_cont ? ST_CRD : ST_RD;
                            end else begin
                                st_q <= ST_WR;
                            end
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_WR: begin
                    rx_q <= {rx_q[WORD_W-3:0], din_s};
                    if (last_bit) begin
                        st_q  <= ST_CMD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_RD: begin
                    if (last_bit) begin
                        st_q  <= ST_CMD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    rx_q <= {rx_q[WORD_W-3:0], din_s};
                    if (exit_hit) begin
                        st_q  <= ST_CMD;
                        cnt_q <= '0;
                    end else if (last_bit) begin
                        cnt_q <= '0;
                        tx_q  <= rd_value << (CNT_W'(WORD_W) - len_q);
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cmd_serial_port.sv
// Top of the command-steered serial register port.
// Assumes a system clock several times faster than the serial clock.
module cmd_serial_port #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] EXIT_CODE   = 8'h30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       din,
    input  logic                       cs_n,
    input  logic                       pol,
    input  logic                       conv_strobe,
    input  logic [csp_pkg::WORD_W-1:0] conv_word,
    output logic                       dout,
    output logic                       rdy_n
);
    import csp_pkg::*;

    logic              sclk_s, din_s, cs_n_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [WORD_W-1:0] rd_value, wr_data;
    logic              wr_en, take, ready;
    port_state_e       eng_state;
    logic [CNT_W-1:0]  eng_cnt;

    csp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pol(pol), .sclk(sclk), .din(din), .cs_n(cs_n),
        .sclk_s(sclk_s), .din_s(din_s), .cs_n_s(cs_n_s)
    );

    csp_shift_engine #(.EXIT_CODE(EXIT_CODE)) u_engine (
        .clk(clk), .rst_n(rst_n), .pol(pol), .sclk_s(sclk_s), .din_s(din_s), .cs_n_s(cs_n_s),
        .rd_value(rd_value), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .take(take), .dout(dout), .st_q(eng_state), .cnt_q(eng_cnt)
    );

    csp_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_value(rd_value), .take(take), .conv_strobe(conv_strobe),
        .conv_word(conv_word), .ready(ready)
    );

    assign rdy_n = ~ready;
endmodule

// File: rtl/csp_checker.sv
// Temporal checks on the serial port, attached to the top by bind.
// Assumes the input conditions listed in the brief's verification section.
module csp_checker
    import csp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             conv_strobe,
    input logic             rdy_n,
    input logic             dout,
    input logic             cs_n_s,
    input port_state_e      st,
    input logic [CNT_W-1:0] cnt,
    input logic             wr_en,
    input logic             take
);
    AST_WRITE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (st == ST_WR) |-> !dout);                    // R6
    AST_STROBE_READY: assert property (@(posedge clk) disable iff (!rst_n) conv_strobe |=> !rdy_n);                    // R9
    AST_TAKE_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (take && !conv_strobe) |=> rdy_n);          // R9
    AST_CS_ABORT:     assert property (@(posedge clk) disable iff (!rst_n) cs_n_s |=> (st == ST_CMD && cnt == '0 && !dout)); // R12
    AST_CNT_LIMIT:    assert property (@(posedge clk) disable iff (!rst_n) cnt < CNT_W'(WORD_W));                      // R2
    AST_CMD_BYTE:     assert property (@(posedge clk) disable iff (!rst_n) (st == ST_CMD) |-> cnt < CNT_W'(8));         // R1
    AST_WR_RETURN:    assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> (st == ST_CMD));                  // R3
endmodule

bind cmd_serial_port csp_checker u_csp_checker (
    .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .rdy_n(rdy_n), .dout(dout),
    .cs_n_s(cs_n_s), .st(eng_state), .cnt(eng_cnt), .wr_en(wr_en), .take(take)
);

// File: tb/cmd_serial_port_bench.sv
module cmd_serial_port_bench;
    localparam int HALF     = 6;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        din = 1'b1;
    logic        cs_n = 1'b0;
    logic        pol = 1'b0;
    logic        conv_strobe = 1'b0;
    logic [23:0] conv_word = '0;
    logic        dout, rdy_n;
    int          checks = 0;
    int          errors = 0;

    cmd_serial_port u_cmd_serial_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .cs_n(cs_n), .pol(pol),
        .conv_strobe(conv_strobe), .conv_word(conv_word), .dout(dout), .rdy_n(rdy_n)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int blen(input logic [2:0] a);
        if (a == 3'd1 || a == 3'd3) return 24;
        if (a == 3'd2) return 16;
        return 8;
    endfunction

    function automatic logic [23:0] cmdb(input logic rd, input logic cont, input logic [2:0] a);
        return {16'h0, 1'b0, rd, 1'b0, cont, 1'b0, a};
    endfunction

    // One serial bit: drive din on the leaving-idle edge, sample dout before the return edge.
    task automatic bitx(input logic b, output logic o);
        @(negedge clk);
        sclk = ~pol;
        din  = b;
        repeat (HALF) @(negedge clk);
        o    = dout;
        sclk = pol;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic shift_word(input logic [23:0] val, input int n, output logic [23:0] got, output int hi);
        logic o;
        got = '0;
        hi  = 0;
        for (int i = n - 1; i >= 0; i--) begin
            bitx(val[i], o);
            got = {got[22:0], o};
            if (o) hi++;
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [23:0] v, output int hi);
        logic [23:0] g;
        int h1, h2;
        shift_word(cmdb(1'b0, 1'b0, a), 8, g, h1);
        shift_word(v, blen(a), g, h2);
        hi = h1 + h2;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [23:0] v);
        logic [23:0] g;
        int h;
        shift_word(cmdb(1'b1, 1'b0, a), 8, g, h);
        shift_word(24'hFFFFFF, blen(a), v, h);
    endtask

    task automatic strobe(input logic [23:0] w);
        @(negedge clk);
        conv_word   = w;
        conv_strobe = 1'b1;
        @(negedge clk);
        conv_strobe = 1'b0;
    endtask

    task automatic do_reset(input logic p);
        @(negedge clk);
        rst_n = 1'b0;
        pol   = p;
        sclk  = p;
        din   = 1'b1;
        cs_n  = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_pass(input logic p);
        logic [23:0] v, g, w1, w2;
        int hi, hisum;
        do_reset(p);
        check($sformatf("R9 reset rdy_n pol=%0d", p), 24'(rdy_n), 24'h1);
        check($sformatf("R6 reset dout pol=%0d", p), 24'(dout), 24'h0);

        // R3 R4 R7: setup register sweep, dout must stay low on writes (R6)
        hisum = 0;
        for (int i = 0; i < 64; i++) begin
            logic [7:0] sv;
            sv = 8'((i * 37 + 91 * p + 5) & 8'hFF);
            write_reg(3'd4, {16'h0, sv}, hi);
            hisum += hi;
            read_reg(3'd4, v);
            check($sformatf("R3 R4 R7 setup %0d pol=%0d", i, p), v, {16'h0, sv});
        end
        check("R6 dout during writes", 24'(hisum), 24'h0);

        // R2 R4: 16-bit mode register
        for (int i = 0; i < 16; i++) begin
            logic [15:0] mv;
            mv = 16'((i * 16'h1F3D) ^ 16'hA5C3);
            write_reg(3'd2, {8'h0, mv}, hi);
            read_reg(3'd2, v);
            check($sformatf("R2 mode %0d", i), v, {8'h0, mv});
        end

        // R5: trailing ones after a 24-bit write, then a partial run of ones
        write_reg(3'd3, 24'h5A0F3C, hi);
        shift_word(24'hFF, 8, g, hi);
        shift_word(24'h7, 3, g, hi);
        read_reg(3'd3, v);
        check("R5 offset after padding", v, 24'h5A0F3C);
        read_reg(3'd2, v);
        check("R5 mode untouched", v, {8'h0, 16'((15 * 16'h1F3D) ^ 16'hA5C3)});

        // R1: leading ones before a command; cont bits on a non-result address give a single read
        shift_word(24'h1F, 5, g, hi);
        shift_word(cmdb(1'b1, 1'b1, 3'd3), 8, g, hi);
        shift_word(24'hFFFFFF, 24, v, hi);
        check("R1 cont bits on offset act as single read", v, 24'h5A0F3C);
        read_reg(3'd3, v);
        check("R1 command wait after that read", v, 24'h5A0F3C);

        // R8 R9: ready flag and status
        read_reg(3'd0, v);
        check("R8 status idle", v, 24'h00);
        strobe(24'hABCDEF);
        @(negedge clk);
        check("R9 rdy_n low after strobe", 24'(rdy_n), 24'h0);
        read_reg(3'd0, v);
        check("R8 status ready", v, 24'h80);
        check("R9 status read keeps ready", 24'(rdy_n), 24'h0);

        // R13: write to read-only result and to unused address
        write_reg(3'd1, 24'h123456, hi);
        write_reg(3'd6, 24'hAA, hi);
        read_reg(3'd6, v);
        check("R13 unused reads zero", v, 24'h0);
        read_reg(3'd1, v);
        check("R13 R4 result unchanged by write", v, 24'hABCDEF);
        check("R9 rdy_n high after result read", 24'(rdy_n), 24'h1);
        read_reg(3'd0, v);
        check("R8 status cleared", v, 24'h00);

        // R10 R11: repeated reading
        write_reg(3'd2, 24'h00C3A5, hi);
        w1 = 24'h13579B ^ {23'h0, p};
        w2 = 24'hE4C2A0;
        strobe(w1);
        shift_word(cmdb(1'b1, 1'b1, 3'd1), 8, g, hi);
        fork
            shift_word(24'hFFFFFF, 24, v, hi);
            begin repeat (100) @(negedge clk); strobe(w2); end
        join
        check("R10 first word", v, w1);
        shift_word(24'hFFFFFF, 24, v, hi);
        check("R10 second word picks new result", v, w2);
        check("R10 ready cleared by word start", 24'(rdy_n), 24'h1);
        shift_word(24'hF30FFF, 24, v, hi);
        check("R11 straddling pattern keeps streaming", v, w2);
        shift_word(24'hFF30, 16, v, hi);
        check("R11 partial word before exit", v, {8'h0, w2[23:8]});
        read_reg(3'd2, v);
        check("R11 command mode after exit", v, 24'h00C3A5);

        // R12: select high aborts and ignores clocks
        shift_word(24'h4, 4, g, hi);
        @(negedge clk); cs_n = 1'b1;
        repeat (8) @(negedge clk);
        write_reg(3'd2, 24'h001111, hi);
        check("R12 dout low while deselected", 24'(hi), 24'h0);
        @(negedge clk); cs_n = 1'b0;
        repeat (8) @(negedge clk);
        read_reg(3'd2, v);
        check("R12 abort and ignored write", v, 24'h00C3A5);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run_pass(1'b0);
        run_pass(1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule